// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits behind a two-wire serial slave front end and turns the two-byte write payload it delivers into register updates for a 10-bit voltage DAC. It holds a staging (input) register, the live DAC register and a 2-bit power-down register. It drives the active DAC code, an output-buffer enable and a termination select for the analog output stage. It also presents two readback bytes for the front end to shift out on a read.

The front end strobes each received byte in with `byte_valid` and pulses `ack_fall` on the falling clock edge of every acknowledge slot. It raises `frame_abort` on STOP, repeated START or any premature end of a transfer. A command takes effect only on the acknowledge falling edge that follows the second byte of a frame. A frame that is cut short changes nothing. After a commit, the next byte starts a new frame, so back-to-back command pairs are accepted without a STOP between them.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, the DAC code and the input register are 0, `term_sel` is 2'b11, `buf_en` is 0, `rd_byte_hi` is 8'h30 and `rd_byte_lo` is 8'h00.
- R2: Frame format. In the first byte, bits [7:4] are the command and bits [3:0] are data bits 9..6. In the second byte, bits [7:2] are data bits 5..0 and bits [1:0] are ignored. Commit happens on the `ack_fall` that follows the second byte, and the next byte is then taken as a new first byte.
- R3: Command 4'b1100 loads the new value into both the input register and the DAC register.
- R4: Command 4'b1101 loads the input register only. `dac_code` is unchanged.
- R5: Command 4'b1110 moves the previous input-register value into the DAC register and stores the new value in the input register.
- R6: Command 4'b1111 copies the input register into the DAC register and ignores both data fields.
- R7: Command 4'b10xx changes no register. The readback bytes are always `rd_byte_hi` = {2'b00, pd[1:0], dac[9:6]} and `rd_byte_lo` = {dac[5:0], 2'b00}.
- R8: Command 4'b01xx loads the power-down register from first-byte bits [3:2]. `term_sel` equals that register: 00 active, 01 floating, 10 low-value resistor, 11 high-value resistor. `buf_en` is 1 only when the register is 00.
- R9: Power-down keeps both data registers. Data commands still update them while powered down, and wake-up (power-down code 00) drives out the stored DAC value.
- R10: `frame_abort` before the committing acknowledge discards the partial frame. The next byte is treated as a first byte.
- R11: Command 4'b00xx changes no state.
- R12: An `ack_fall` that does not follow a second byte (an address or first-byte acknowledge) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe: a received payload byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| ack_fall | input | 1 | One-cycle strobe at the falling clock edge of an acknowledge slot |
| frame_abort | input | 1 | STOP, repeated START or premature end of transfer |
| dac_code | output | 10 | Current DAC register value |
| buf_en | output | 1 | Output buffer enable |
| term_sel | output | 2 | Output termination select (power-down state) |
| rd_byte_hi | output | 8 | First readback byte |
| rd_byte_lo | output | 8 | Second readback byte |

## Verification
The bench runs command pairs that expose ordering mistakes.

- **1101 followed by 1110.** A controller that copied the new value instead of the old staged one would show the wrong code after 1110.
- **1111 with junk data.** Sending 1111 with junk in both data fields catches a design that loads the data bits.
- **Writes while powered down, then wake-up.** Data writes during power-down followed by a wake-up command with set don't-care bits would lose the code, or fail to restore it.
- **Aborts and early acknowledges.** Aborts after the first byte, and acknowledges after the first byte, would cause early or stray commits. Nonzero sub-bits must not leak into the code.

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl #(
  parameter logic [1:0] RESET_PD = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       ack_fall,
  input  logic       frame_abort,
  output logic [9:0] dac_code,
  output logic       buf_en,
  output logic [1:0] term_sel,
  output logic [7:0] rd_byte_hi,
  output logic [7:0] rd_byte_lo
);

  typedef enum logic [1:0] {P_FIRST, P_SECOND, P_WAIT} phase_t;

  phase_t     ph;
  logic [3:0] cmd_q, hi_q;
  logic [5:0] lo_q;
  logic [9:0] in_q, dac_q;
  logic [1:0] pd_q;
  logic       commit;
  logic [9:0] nv;

  assign nv     = {hi_q, lo_q};
  assign commit = ack_fall && (ph == P_WAIT) && !frame_abort && !byte_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= P_FIRST;
      cmd_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (frame_abort) begin
      ph <= P_FIRST;
    end else if (byte_valid) begin
      if (ph == P_SECOND) begin
        lo_q <= byte_data[7:2];
        ph   <= P_WAIT;
      end else begin
        cmd_q <= byte_data[7:4];
        hi_q  <= byte_data[3:0];
        ph    <= P_SECOND;
      end
    end else if (commit) begin
      ph <= P_FIRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= RESET_PD;
    end else if (commit) begin
      casez (cmd_q)
        4'b1100: begin in_q <= nv; dac_q <= nv; end
        4'b1101: in_q <= nv;
        4'b1110: begin dac_q <= in_q; in_q <= nv; end
        4'b1111: dac_q <= in_q;
        4'b01??: pd_q <= hi_q[3:2];
        default: ;
      endcase
    end
  end

  assign dac_code   = dac_q;
  assign term_sel   = pd_q;
  assign buf_en     = (pd_q == 2'b00);
  assign rd_byte_hi = {2'b00, pd_q, dac_q[9:6]};
  assign rd_byte_lo = {dac_q[5:0], 2'b00};

  a_r12_no_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fall |=> $stable(dac_code) && $stable(term_sel));

  a_r10_abort_discards: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> $stable(dac_code) && $stable(term_sel));

  a_r4_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_q == 4'b1101) |=> $stable(dac_code) && in_q == $past(nv));

  a_r5_swap_old: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_q == 4'b1110) |=> dac_code == $past(in_q) && in_q == $past(nv));

  a_r6_copy_input: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_q == 4'b1111) |=> dac_code == $past(in_q) && $stable(in_q));

  a_r7_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_q[3:2] == 2'b10) |=> $stable(dac_code) && $stable(in_q) && $stable(term_sel));

  a_r11_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_q[3:2] == 2'b00) |=> $stable(dac_code) && $stable(in_q) && $stable(term_sel));

endmodule

// File: tb/tb_dac_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_dac_cmd_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       byte_valid = 0;
  logic [7:0] byte_data = 0;
  logic       ack_fall = 0;
  logic       frame_abort = 0;
  logic [9:0] dac_code;
  logic       buf_en;
  logic [1:0] term_sel;
  logic [7:0] rd_byte_hi, rd_byte_lo;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dac_cmd_ctrl dut (.*);

  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {8'h40, 8'h00, 10'h000, 2'd0},  // R8 wake
    {8'hCA, 8'h94, 10'h2A5, 2'd0},  // R3 load both
    {8'hD4, 8'hF0, 10'h2A5, 2'd0},  // R4 input only (in=13C)
    {8'hEF, 8'hFC, 10'h13C, 2'd0},  // R5 old input to dac
    {8'hF5, 8'h57, 10'h3FF, 2'd0},  // R6 copy input, junk data
    {8'h8F, 8'hFF, 10'h3FF, 2'd0},  // R7 read request
    {8'h3F, 8'hFF, 10'h3FF, 2'd0},  // R11 no-op
    {8'h4B, 8'hAA, 10'h3FF, 2'd2},  // R8 low-value termination
    {8'hC0, 8'h04, 10'h001, 2'd2},  // R9 write while down
    {8'h44, 8'h00, 10'h001, 2'd1},  // R8 float
    {8'h73, 8'h00, 10'h001, 2'd0},  // R9 wake restores
    {8'hC8, 8'h03, 10'h200, 2'd0}   // R2 sub-bits ignored
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1; byte_data = b;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_fall = 1;
    @(negedge clk); ack_fall = 0;
  endtask

  task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1);
    send_byte(b0); pulse_ack(); send_byte(b1); pulse_ack();
  endtask

  task automatic check_out(input string req, input logic [9:0] d, input logic [1:0] pd);
    check(req, dac_code, d);
    check(req, term_sel, pd);
    check(req, buf_en, pd == 2'b00);
    check({req, "_R7_rd"}, {rd_byte_hi, rd_byte_lo}, {2'b00, pd, d, 2'b00});
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_out("R1", 10'h000, 2'b11);

    for (int i = 0; i < NV; i++) begin
      send_frame(VEC[i][27:20], VEC[i][19:12]);
      check_out($sformatf("vec%0d", i), VEC[i][11:2], VEC[i][1:0]);
    end

    // R12: acknowledge after first byte only, then stray acknowledge
    send_byte(8'hC1); pulse_ack();
    check_out("R12", 10'h200, 2'd0);
    pulse_ack();
    check_out("R12", 10'h200, 2'd0);
    send_byte(8'h00); pulse_ack();
    check_out("R2", 10'h040, 2'd0);

    // R10: abort after first byte, then after second byte
    send_byte(8'hCF);
    @(negedge clk); frame_abort = 1; @(negedge clk); frame_abort = 0;
    pulse_ack();
    check_out("R10", 10'h040, 2'd0);
    send_byte(8'hCF); send_byte(8'hFC);
    @(negedge clk); frame_abort = 1; @(negedge clk); frame_abort = 0;
    pulse_ack();
    check_out("R10", 10'h040, 2'd0);
    send_frame(8'hC3, 8'h08);
    check_out("R10", 10'h0C2, 2'd0);

    // R2: back-to-back frames without abort
    send_frame(8'hD0, 8'h04);
    send_frame(8'hE0, 8'h08);
    check_out("R5", 10'h001, 2'd0);
    send_frame(8'hF0, 8'h00);
    check_out("R6", 10'h002, 2'd0);

    // R1: reset mid-operation
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check_out("R1", 10'h000, 2'b11);
    send_frame(8'hFF, 8'hFF);
    check_out("R1", 10'h000, 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule